// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Peripheral

This block is a multiplier that a small 16-bit processor reaches over a simple synchronous register bus. Software first writes operand A to one of four word addresses. The address it picks sets the operation: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Software then writes operand B. The write of operand B starts the operation, and the 32-bit result is in the result registers on the edge of that same write. The next bus read returns it, with no wait.

Either operand may be loaded as a full word or as a single byte, so 16×16, 16×8, 8×16 and 8×8 products are all supported. In multiply-accumulate modes each new product is added to the 32-bit value held in the two result words. Software can load those words directly to seed the sum. A third result word extends the sum: it holds the sign in signed modes and the carry in unsigned accumulation.

Top module: `mac_periph`

## Requirements
- R1: After reset, the low, high and extension result words and operand A all read zero, and the latched mode is unsigned multiply.
- R2: A write to word 0, 1, 2 or 3 loads operand A and latches the mode: 0 is unsigned multiply, 1 is signed multiply, 2 is unsigned accumulate and 3 is signed accumulate. A read of any of these four words returns operand A.
- R3: A write to word 4 (operand B) performs the operation on the clock edge of that write. The result is readable at word 5 (bits 15:0) and word 6 (bits 31:16) in the cycle that follows.
- R4: Unsigned multiply places the unsigned 32-bit product in words 5 and 6, and word 7 reads zero.
- R5: Signed multiply treats both operands as two's complement. Word 7 reads 16'hFFFF when the product is negative and zero otherwise, and this holds at the most negative operand values.
- R6: Unsigned accumulate replaces {word 6, word 5} with that value plus the unsigned product, modulo 2^32. Word 7 reads the carry out of this addition, as 0 or 1.
- R7: Signed accumulate adds the signed product, taken as a 32-bit two's-complement value, to {word 6, word 5}, modulo 2^32. Word 7 reads 16'hFFFF when bit 31 of the new sum is set and zero otherwise.
- R8: A write whose byte enable is not 2'b11 (and not 2'b00) is a byte write. It takes only bits 7:0 of the write data. That byte is zero-extended in unsigned modes and sign-extended from bit 7 in signed modes. Operand A follows the mode of its own address and operand B follows the latched mode. Word 4 reads back the extended operand B.
- R9: A second write to operand B alone repeats the operation with the operand A and mode already latched.
- R10: Writes to words 5 and 6 preload the result, and only the byte lanes whose enable bit is set (bit 0 for bits 7:0, bit 1 for bits 15:8) change. Such writes perform no arithmetic.
- R11: Word 7 is read-only, and writing it changes no result word.
- R12: The result words hold their values through any cycle with no write to words 4, 5 or 6, including writes to operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Word index of the access |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_be | input | DATA_W/8 (2) | Byte enables of the write |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr, combinational |

## Verification
A vector table runs all four modes with word and byte operands. It uses the operand values that separate the modes: 16'h8000 and 16'hFFFF, which give different products as signed and unsigned values, and byte operands whose upper data lane carries junk and whose bit 7 is set, which separate zero extension from sign extension. Accumulate vectors start from preloads chosen to force a carry out, a signed wrap past bit 31 and a sign change from positive to negative, so the extension word is tested in each mode. Directed sequences then cover the reset state, a repeated operand-B write, a partial-lane preload, a write to the read-only word and operand-A writes that must leave the result alone.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      MODE_UMUL = 2'd0,
      MODE_SMUL = 2'd1,
      MODE_UMAC = 2'd2,
      MODE_SMAC = 2'd3
   } mac_mode_e;

   // word indices on the register bus
   localparam int unsigned WI_OPB    = 4;
   localparam int unsigned WI_RES_LO = 5;
   localparam int unsigned WI_RES_HI = 6;
   localparam int unsigned WI_RES_EX = 7;

   function automatic logic mode_is_signed(input mac_mode_e m);
      return m[0];
   endfunction

   function automatic logic mode_is_acc(input mac_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0]   raw,
   input  logic [DATA_W/8-1:0] be,
   input  logic                sgn,
   output logic [DATA_W-1:0]   opnd
);
   localparam int unsigned BE_W = DATA_W / 8;

   logic byte_acc;
   assign byte_acc = (be != {BE_W{1'b1}});

   always_comb begin
      if (!byte_acc)
         opnd = raw;
      else if (sgn)
         opnd = {{(DATA_W-8){raw[7]}}, raw[7:0]};
      else
         opnd = {{(DATA_W-8){1'b0}}, raw[7:0]};
   end

endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  logic                sgn,
   input  logic                acc_en,
   input  logic [2*DATA_W-1:0] acc_in,
   output logic [2*DATA_W-1:0] res,
   output logic [DATA_W-1:0]   ext
);
   localparam int unsigned OW = DATA_W + 1;
   localparam int unsigned PW = 2 * OW;
   localparam int unsigned RW = 2 * DATA_W;

   logic signed [OW-1:0] xa, xb;
   logic signed [PW-1:0] prod_full;
   logic [RW-1:0]        prod;
   logic [RW:0]          sum;

   // one extra bit per operand lets one signed multiplier serve both modes
   assign xa        = $signed({sgn & opa[DATA_W-1], opa});
   assign xb        = $signed({sgn & opb[DATA_W-1], opb});
   assign prod_full = xa * xb;
   assign prod      = prod_full[RW-1:0];
   assign sum       = {1'b0, acc_in} + {1'b0, prod};

   always_comb begin
      res = acc_en ? sum[RW-1:0] : prod;
      if (sgn)
         ext = {DATA_W{res[RW-1]}};
      else if (acc_en)
         ext = {{(DATA_W-1){1'b0}}, sum[RW]};
      else
         ext = '0;
   end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
   import mac_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic                bus_we,
   output logic [DATA_W-1:0]   bus_rdata
);
   localparam int unsigned BE_W = DATA_W / 8;
   localparam int unsigned RW   = 2 * DATA_W;

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("mac_periph: DATA_W must be a multiple of 8, at least 16");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("mac_periph: ADDR_W must be at least 3");
      end
   endgenerate

   mac_mode_e         mode_q;
   logic [DATA_W-1:0] opa_q, opb_q, lo_q, hi_q, ex_q;
   logic [DATA_W-1:0] lo_nxt, hi_nxt;
   logic [DATA_W-1:0] opnd;
   logic [RW-1:0]     res;
   logic [DATA_W-1:0] res_ext;
   logic              wr, wr_opa, wr_opb, wr_lo, wr_hi, ext_sgn;

   assign wr     = bus_we && (bus_be != '0);
   assign wr_opa = wr && (bus_addr[ADDR_W-1:2] == '0);
   assign wr_opb = wr && (bus_addr == ADDR_W'(WI_OPB));
   assign wr_lo  = wr && (bus_addr == ADDR_W'(WI_RES_LO));
   assign wr_hi  = wr && (bus_addr == ADDR_W'(WI_RES_HI));

   // operand A takes its sign rule from its own address, operand B from the latch
   assign ext_sgn = wr_opa ? bus_addr[0] : mode_is_signed(mode_q);

   mac_opnd_ext #(.DATA_W(DATA_W)) u_ext (
      .raw  (bus_wdata),
      .be   (bus_be),
      .sgn  (ext_sgn),
      .opnd (opnd)
   );

   mac_arith #(.DATA_W(DATA_W)) u_arith (
      .opa    (opa_q),
      .opb    (opnd),
      .sgn    (mode_is_signed(mode_q)),
      .acc_en (mode_is_acc(mode_q)),
      .acc_in ({hi_q, lo_q}),
      .res    (res),
      .ext    (res_ext)
   );

   // lane-wise merge for result preload
   generate
      for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
         assign lo_nxt[8*ln +: 8] = bus_be[ln] ? bus_wdata[8*ln +: 8] : lo_q[8*ln +: 8];
         assign hi_nxt[8*ln +: 8] = bus_be[ln] ? bus_wdata[8*ln +: 8] : hi_q[8*ln +: 8];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_UMUL;
         opa_q  <= '0;
         opb_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         ex_q   <= '0;
      end else begin
         if (wr_opa) begin
            opa_q  <= opnd;
            mode_q <= mac_mode_e'(bus_addr[1:0]);
         end
         if (wr_opb) begin
            opb_q <= opnd;
            lo_q  <= res[DATA_W-1:0];
            hi_q  <= res[RW-1:DATA_W];
            ex_q  <= res_ext;
         end
         if (wr_lo) lo_q <= lo_nxt;
         if (wr_hi) hi_q <= hi_nxt;
      end
   end

   always_comb begin
      if (bus_addr[ADDR_W-1:2] == '0)               bus_rdata = opa_q;
      else if (bus_addr == ADDR_W'(WI_OPB))          bus_rdata = opb_q;
      else if (bus_addr == ADDR_W'(WI_RES_LO))       bus_rdata = lo_q;
      else if (bus_addr == ADDR_W'(WI_RES_HI))       bus_rdata = hi_q;
      else if (bus_addr == ADDR_W'(WI_RES_EX))       bus_rdata = ex_q;
      else                                           bus_rdata = '0;
   end

   // R4: unsigned multiply never leaves a nonzero extension
   a_r4_umul_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && mode_q == MODE_UMUL) |=> (ex_q == '0));

   // R5 / R7: signed extension is all ones or all zeros, matching bit 31
   a_r7_signed_ext_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && mode_is_signed(mode_q)) |=> (ex_q == {DATA_W{hi_q[DATA_W-1]}}));

   // R6: unsigned accumulate extension is a single carry bit
   a_r6_umac_carry_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opb && mode_q == MODE_UMAC) |=> (ex_q[DATA_W-1:1] == '0));

   // R12 / R11: result words hold without a write to words 4..6
   a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_opb || wr_lo || wr_hi) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ex_q)));

   // R2: operand A write latches the mode named by its address
   a_r2_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
      wr_opa |=> (mode_q == mac_mode_e'($past(bus_addr[1:0]))));

endmodule

// File: tb/mac_periph_tb.sv
module mac_periph_tb;

   localparam int unsigned W  = 16;
   localparam int unsigned AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [1:0]    bus_be = 2'b11;
   logic          bus_we = 1'b0;
   logic [W-1:0]  bus_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   mac_periph #(.DATA_W(W), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic        a_byte;
      logic        b_byte;
      logic        pre;
      logic [31:0] acc;
      logic [15:0] a;
      logic [15:0] b;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VT [NV] = '{
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,        16'h1234, 16'h5678},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0,        16'hFFFF, 16'hFFFF},
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,        16'h8000, 16'h8000},
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,        16'h8000, 16'h7FFF},
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0,        16'hFFFF, 16'h0001},
      '{2'd0, 1'b1, 1'b1, 1'b0, 32'h0,        16'hAB80, 16'hCDFF},
      '{2'd1, 1'b1, 1'b1, 1'b0, 32'h0,        16'h5580, 16'h3380},
      '{2'd1, 1'b1, 1'b0, 1'b0, 32'h0,        16'h12FF, 16'h1234},
      '{2'd0, 1'b0, 1'b1, 1'b0, 32'h0,        16'h1234, 16'hEE12},
      '{2'd2, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 16'h0001, 16'h0001},
      '{2'd2, 1'b0, 1'b0, 1'b1, 32'h00010000, 16'h0100, 16'h0100},
      '{2'd3, 1'b0, 1'b0, 1'b1, 32'h00000005, 16'hFFFE, 16'h0003},
      '{2'd3, 1'b0, 1'b0, 1'b1, 32'h80000000, 16'hFFFF, 16'h0001},
      '{2'd3, 1'b1, 1'b1, 1'b1, 32'h00000000, 16'h9980, 16'h447F}
   };

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [1:0] be);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_be    = be;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_be    = 2'b11;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #1ns;
      d = bus_rdata;
   endtask

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] ext_op(input logic [15:0] d, input logic byt, input logic sgn);
      if (!byt) return d;
      return sgn ? {{8{d[7]}}, d[7:0]} : {8'h00, d[7:0]};
   endfunction

   // independent model of the requirements R4..R8
   function automatic logic [47:0] model(input logic [1:0] mode, input logic [15:0] a,
                                         input logic [15:0] b, input logic [31:0] acc);
      logic sgn, mac;
      longint pa, pb, pr, s;
      logic [31:0] r;
      logic [15:0] e;
      sgn = mode[0];
      mac = mode[1];
      pa = sgn ? longint'($signed(a)) : longint'(a);
      pb = sgn ? longint'($signed(b)) : longint'(b);
      pr = pa * pb;
      s  = longint'(acc) + longint'(pr[31:0]);
      r  = mac ? s[31:0] : pr[31:0];
      if (sgn)      e = {16{r[31]}};
      else if (mac) e = {15'b0, s[32]};
      else          e = 16'h0;
      return {e, r};
   endfunction

   initial begin
      #2ms;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [31:0] acc_m;
      logic [47:0] ex;
      string tg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      rd(3'd5, v); check("R1 lo", v, 16'h0);
      rd(3'd6, v); check("R1 hi", v, 16'h0);
      rd(3'd7, v); check("R1 ext", v, 16'h0);
      rd(3'd0, v); check("R1 opa", v, 16'h0);
      // R1: unsigned multiply mode after reset: a lone operand-B write multiplies 0
      wr(3'd4, 16'h7777, 2'b11);
      rd(3'd5, v); check("R1 mode lo", v, 16'h0);

      acc_m = 32'h0;
      for (int i = 0; i < NV; i++) begin
         logic [15:0] ea, eb;
         if (VT[i].pre) begin
            wr(3'd5, VT[i].acc[15:0], 2'b11);
            wr(3'd6, VT[i].acc[31:16], 2'b11);
            acc_m = VT[i].acc;
         end
         wr({1'b0, VT[i].mode}, VT[i].a, VT[i].a_byte ? 2'b01 : 2'b11);
         wr(3'd4, VT[i].b, VT[i].b_byte ? 2'b01 : 2'b11);
         ea = ext_op(VT[i].a, VT[i].a_byte, VT[i].mode[0]);
         eb = ext_op(VT[i].b, VT[i].b_byte, VT[i].mode[0]);
         ex = model(VT[i].mode, ea, eb, acc_m);
         acc_m = ex[31:0];
         case (VT[i].mode)
            2'd0: tg = "R4";
            2'd1: tg = "R5";
            2'd2: tg = "R6";
            default: tg = "R7";
         endcase
         if (VT[i].a_byte || VT[i].b_byte) tg = {tg, "/R8"};
         tg = $sformatf("%s/R3 vec %0d", tg, i);
         rd(3'd5, v); check({tg, " lo"}, v, ex[15:0]);
         rd(3'd6, v); check({tg, " hi"}, v, ex[31:16]);
         rd(3'd7, v); check({tg, " ext"}, v, ex[47:32]);
      end

      // R2: operand A readback and mode latch
      wr(3'd2, 16'h4321, 2'b11);
      rd(3'd3, v); check("R2 opa readback", v, 16'h4321);
      // R10: full preload to zero, then R9: repeated operand B accumulates
      wr(3'd5, 16'h0000, 2'b11);
      wr(3'd6, 16'h0000, 2'b11);
      rd(3'd5, v); check("R10 preload lo", v, 16'h0);
      wr(3'd4, 16'h0002, 2'b11);
      rd(3'd5, v); check("R3 first lo", v, 16'h8642);
      wr(3'd4, 16'h0002, 2'b11);
      rd(3'd5, v); check("R9 repeat lo", v, 16'h0C84);
      rd(3'd6, v); check("R9 repeat hi", v, 16'h0001);
      rd(3'd7, v); check("R9 repeat ext", v, 16'h0000);

      // R10: upper lane only
      wr(3'd6, 16'hAA55, 2'b10);
      rd(3'd6, v); check("R10 lane hi", v, 16'hAA01);
      rd(3'd5, v); check("R10 lo kept", v, 16'h0C84);

      // R11: extension word is read-only
      wr(3'd7, 16'hFFFF, 2'b11);
      rd(3'd7, v); check("R11 ext", v, 16'h0000);
      rd(3'd5, v); check("R11 lo", v, 16'h0C84);

      // R12: operand A write leaves results alone
      wr(3'd1, 16'h0003, 2'b11);
      rd(3'd5, v); check("R12 lo", v, 16'h0C84);
      rd(3'd6, v); check("R12 hi", v, 16'hAA01);

      // R8: byte operand B in signed multiply, sign-extended, readback on word 4
      wr(3'd4, 16'h12F0, 2'b01);
      rd(3'd4, v); check("R8 opb readback", v, 16'hFFF0);
      rd(3'd5, v); check("R8 signed byte lo", v, 16'hFFD0);
      rd(3'd6, v); check("R8 signed byte hi", v, 16'hFFFF);
      rd(3'd7, v); check("R5 ext neg", v, 16'hFFFF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule